// File: doc/BRIEF.md
# Reloadable System Watchdog Timer

This block is a watchdog timer peripheral programmed over a small byte/halfword register bus. A prescaler divides the system clock into coarse ticks, and a down-counter loads from a programmable initial value and steps down by one on each tick. Software keeps the system alive by writing the reload code before the count runs out. It can also halt the count, read the ticks remaining and program a new timeout.

When the count expires, the counter reloads itself and a timeout status flag is set. If a second expiry follows with no reload in between, the block raises a second-timeout flag and pulses a system reset request. A reboot-inhibit bit can block that request. At reset the timer comes up halted with the inhibit set, so nothing runs until software enables it.

A parameter picks one of two variants: a narrow one with a 6-bit count, byte reload writes and the initial value at offset 0x01, or a wide one with a 10-bit count, halfword reload writes and the initial value at offset 0x12.

Top module: `wdt_timer`

## Requirements
- R1: After reset these hold: the halt bit (offset 0x08, bit 11) is 1, the reboot-inhibit bit (offset 0x0A, bit 0) is 1, the initial value and the count both equal INIT_DEFAULT (50), both status registers read 0, and rst_req is low.
- R2: While the halt bit is 0, the count drops by one every TICK_DIV clocks. While it is 1, both the prescaler and the count hold. The halt bit reads back as written, and the other bits of offset 0x08 read 0.
- R3: The initial value sits in bits [9:0] of offset 0x12 (wide) or bits [5:0] of offset 0x01 (narrow). A write of 0 to 3 leaves the stored value unchanged. Bits above the field are ignored on write and read as 0.
- R4: Writing exactly 1 to offset 0x00 loads the count from the initial value, restarts the prescaler and cancels any pending first expiry. The write must be a halfword (bus_size=1) in the wide variant or a byte (bus_size=0) in the narrow variant. A write of any other value or size has no effect.
- R5: A read of offset 0x00 returns the current count in its low 6 or 10 bits, with zeros above.
- R6: A tick that arrives while the count is 0 is an expiry. It reloads the count from the initial value and sets bit 3 of offset 0x04, so one period lasts initial value + 1 ticks.
- R7: Status bits are write-one-to-clear. A 0 written to a bit leaves it unchanged, and a new event wins over a clear in the same cycle.
- R8: A second expiry with no reload since the first sets bit 1 of offset 0x06. If the reboot-inhibit bit is 0, it also drives rst_req high for exactly one cycle, starting at the same clock edge. The expiry after that counts as a first one again.
- R9: The reboot-inhibit bit is readable and writable. While it is 1, no expiry produces rst_req.
- R10: A valid reload between two expiries means the later expiry counts as a first one: no second-timeout flag and no rst_req.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 1 | 0 = byte, 1 = halfword |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when not selected) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the wide variant (WIDE=1) with TICK_DIV=4 and INIT_DEFAULT=50. Because a programmed initial value of 5 then gives a 24-clock period, back-to-back expiries, second-expiry reset pulses and reload-cancelled sequences all fit within a few hundred cycles. The 60-clock halted interval right after reset confirms that the default value of 50 does not move. The bench model also follows a narrow build if its WIDE localparam is set to 0, which exercises byte-sized reloads and the 6-bit field.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [4:0] ADDR_RELOAD = 5'h00;
    localparam logic [4:0] ADDR_INIT_N = 5'h01;
    localparam logic [4:0] ADDR_STS1   = 5'h04;
    localparam logic [4:0] ADDR_STS2   = 5'h06;
    localparam logic [4:0] ADDR_CTL1   = 5'h08;
    localparam logic [4:0] ADDR_CTL2   = 5'h0A;
    localparam logic [4:0] ADDR_INIT_W = 5'h12;

    localparam int HALT_BIT    = 11;
    localparam int TIMEOUT_BIT = 3;
    localparam int SECOND_BIT  = 1;
    localparam int INHIBIT_BIT = 0;
    localparam int INIT_FLOOR  = 4;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_HALF = 1'b1
    } bus_size_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.phase == LAST);
        if (restart) begin
            s_d.phase = '0;
        end else if (run) begin
            s_d.phase = tick ? '0 : s_q.phase + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CW       = 10,
    parameter int INIT_RST = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          reload,
    input  logic [CW-1:0] init_val,
    output logic [CW-1:0] count,
    output logic          expire,
    output logic          second
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic          armed;
    } cd_t;

    cd_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        expire = 1'b0;
        second = 1'b0;
        if (reload) begin
            s_d.count = init_val;
            s_d.armed = 1'b0;
        end else if (tick) begin
            if (s_q.count == '0) begin
                s_d.count = init_val;
                expire    = 1'b1;
                second    = s_q.armed;
                s_d.armed = !s_q.armed;
            end else begin
                s_d.count = s_q.count - CW'(1);
            end
        end
    end

    assign count = s_q.count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.count <= CW'(INIT_RST);
            s_q.armed <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdt_regfile.sv
module wdt_regfile
    import wdt_pkg::*;
#(
    parameter int WIDE     = 1,
    parameter int CW       = 10,
    parameter int INIT_RST = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic          bus_size,
    input  logic [4:0]    bus_addr,
    input  logic [15:0]   bus_wdata,
    output logic [15:0]   bus_rdata,
    input  logic [CW-1:0] count,
    input  logic          expire,
    input  logic          second,
    output logic          reload,
    output logic          halt,
    output logic          inhibit,
    output logic [CW-1:0] init_val,
    output logic          rst_req
);
    localparam logic [4:0] INIT_ADDR = (WIDE != 0) ? ADDR_INIT_W : ADDR_INIT_N;

    typedef struct packed {
        logic          halt;
        logic          inhibit;
        logic [CW-1:0] init;
        logic          sts_timeout;
        logic          sts_second;
        logic          rst;
    } reg_t;

    reg_t s_d, s_q;
    logic wr;
    logic reload_ok;
    logic [CW-1:0] new_init;

    always_comb begin
        s_d      = s_q;
        wr       = bus_sel && bus_wr;
        new_init = bus_wdata[CW-1:0];

        if (WIDE != 0) begin
            reload_ok = (bus_size == SZ_HALF) && (bus_wdata == 16'h0001);
        end else begin
            reload_ok = (bus_size == SZ_BYTE) && (bus_wdata[7:0] == 8'h01);
        end
        reload = wr && (bus_addr == ADDR_RELOAD) && reload_ok;

        if (wr && (bus_addr == INIT_ADDR) && (new_init >= CW'(INIT_FLOOR))) begin
            s_d.init = new_init;
        end
        if (wr && (bus_addr == ADDR_CTL1)) s_d.halt    = bus_wdata[HALT_BIT];
        if (wr && (bus_addr == ADDR_CTL2)) s_d.inhibit = bus_wdata[INHIBIT_BIT];

        s_d.sts_timeout = expire |
            (s_q.sts_timeout & ~(wr && (bus_addr == ADDR_STS1) && bus_wdata[TIMEOUT_BIT]));
        s_d.sts_second  = second |
            (s_q.sts_second & ~(wr && (bus_addr == ADDR_STS2) && bus_wdata[SECOND_BIT]));

        s_d.rst = second && !s_q.inhibit;

        bus_rdata = '0;
        if (bus_sel) begin
            case (bus_addr)
                ADDR_RELOAD: bus_rdata[CW-1:0]    = count;
                INIT_ADDR:   bus_rdata[CW-1:0]    = s_q.init;
                ADDR_STS1:   bus_rdata[TIMEOUT_BIT] = s_q.sts_timeout;
                ADDR_STS2:   bus_rdata[SECOND_BIT]  = s_q.sts_second;
                ADDR_CTL1:   bus_rdata[HALT_BIT]    = s_q.halt;
                ADDR_CTL2:   bus_rdata[INHIBIT_BIT] = s_q.inhibit;
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign halt     = s_q.halt;
    assign inhibit  = s_q.inhibit;
    assign init_val = s_q.init;
    assign rst_req  = s_q.rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.halt        <= 1'b1;
            s_q.inhibit     <= 1'b1;
            s_q.init        <= CW'(INIT_RST);
            s_q.sts_timeout <= 1'b0;
            s_q.sts_second  <= 1'b0;
            s_q.rst         <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int WIDE         = 1,
    parameter int TICK_DIV     = 1000,
    parameter int INIT_DEFAULT = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic        bus_size,
    input  logic [4:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        rst_req
);
    localparam int CW = (WIDE != 0) ? 10 : 6;

    logic          tick;
    logic          reload;
    logic          halt;
    logic          inhibit;
    logic [CW-1:0] init_val;
    logic [CW-1:0] count;
    logic          expire;
    logic          second;

    wdt_prescaler #(.TICK_DIV(TICK_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (!halt),
        .restart (reload),
        .tick    (tick)
    );

    wdt_countdown #(.CW(CW), .INIT_RST(INIT_DEFAULT)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .reload   (reload),
        .init_val (init_val),
        .count    (count),
        .expire   (expire),
        .second   (second)
    );

    wdt_regfile #(.WIDE(WIDE), .CW(CW), .INIT_RST(INIT_DEFAULT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_size  (bus_size),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count),
        .expire    (expire),
        .second    (second),
        .reload    (reload),
        .halt      (halt),
        .inhibit   (inhibit),
        .init_val  (init_val),
        .rst_req   (rst_req)
    );
endmodule

// File: rtl/wdt_timer_chk.sv
module wdt_timer_chk #(
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          halt,
    input logic          reload,
    input logic          inhibit,
    input logic          expire,
    input logic [CW-1:0] init_val,
    input logic [CW-1:0] count,
    input logic          rst_req,
    input logic [15:0]   bus_rdata
);
    assert_halt_freeze_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !reload) |=> $stable(count));

    assert_init_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        init_val >= CW'(4));

    assert_reload_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (count == $past(init_val)));

    assert_expire_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (count == $past(init_val)));

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_inhibit_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> !$past(inhibit));
endmodule

bind wdt_timer wdt_timer_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt      (halt),
    .reload    (reload),
    .inhibit   (inhibit),
    .expire    (expire),
    .init_val  (init_val),
    .count     (count),
    .rst_req   (rst_req),
    .bus_rdata (bus_rdata)
);

// File: tb/tb_wdt_timer.sv
module tb_wdt_timer;
    localparam int WIDE  = 1;
    localparam int DIV   = 4;
    localparam int INIT  = 50;
    localparam int FMASK = (WIDE != 0) ? 1023 : 63;
    localparam logic [4:0] A_INIT = (WIDE != 0) ? 5'h12 : 5'h01;
    localparam logic       RSZ    = (WIDE != 0) ? 1'b1 : 1'b0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic        size = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    bit done = 1'b0;

    int m_pre, m_cnt, m_init;
    bit m_arm, m_halt, m_inh, m_sto, m_ssec, m_rst;

    always #10 clk = ~clk;

    wdt_timer #(.WIDE(WIDE), .TICK_DIV(DIV), .INIT_DEFAULT(INIT)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (sel),
        .bus_wr    (wr),
        .bus_size  (size),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .rst_req   (rst_req)
    );

    // Behavioural reference model, advanced once per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre <= 0; m_cnt <= INIT; m_init <= INIT; m_arm <= 1'b0;
            m_halt <= 1'b1; m_inh <= 1'b1; m_sto <= 1'b0; m_ssec <= 1'b0; m_rst <= 1'b0;
        end else begin : model
            bit w, rl, tk, ex, sc;
            int fv;
            w  = sel && wr;
            rl = w && addr == 5'h00 &&
                 ((WIDE != 0) ? (size == 1'b1 && wdata == 16'h0001)
                              : (size == 1'b0 && wdata[7:0] == 8'h01));
            tk = !m_halt && (m_pre == DIV - 1);
            ex = 1'b0; sc = 1'b0;
            if (rl) m_pre <= 0;
            else if (!m_halt) m_pre <= tk ? 0 : m_pre + 1;
            if (rl) begin
                m_cnt <= m_init; m_arm <= 1'b0;
            end else if (tk) begin
                if (m_cnt == 0) begin
                    m_cnt <= m_init; ex = 1'b1; sc = m_arm; m_arm <= !m_arm;
                end else begin
                    m_cnt <= m_cnt - 1;
                end
            end
            fv = int'(wdata) & FMASK;
            if (w && addr == A_INIT && fv >= 4) m_init <= fv;
            if (w && addr == 5'h08) m_halt <= wdata[11];
            if (w && addr == 5'h0A) m_inh <= wdata[0];
            m_sto  <= ex || (m_sto && !(w && addr == 5'h04 && wdata[3]));
            m_ssec <= sc || (m_ssec && !(w && addr == 5'h06 && wdata[1]));
            m_rst  <= sc && !m_inh;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Every-clock comparison of the reset request (R8, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R8 rst_req vs model", {31'b0, rst_req}, {31'b0, m_rst});
            if (rst_req) n_pulse++;
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic sz, input logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; size = sz; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] held;
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'h08, v); check("R1 halt after reset", v, 16'h0800);
        bus_read(5'h0A, v); check("R1 inhibit after reset", v, 16'h0001);
        bus_read(A_INIT, v); check("R1 init after reset", v, 16'(INIT));
        bus_read(5'h00, v); check("R1 count after reset", v, 16'(INIT));
        bus_read(5'h04, v); check("R1 sts1 after reset", v, 16'h0000);
        bus_read(5'h06, v); check("R1 sts2 after reset", v, 16'h0000);
        check("R1 rst_req low", {31'b0, rst_req}, 32'd0);

        // R2 halted counter holds
        idle(60);
        bus_read(5'h00, v); check("R2 halted count holds", v, 16'(INIT));

        // R3 initial value programming
        bus_write(A_INIT, RSZ, 16'd5);    bus_read(A_INIT, v); check("R3 init write 5", v, 16'd5);
        bus_write(A_INIT, RSZ, 16'd3);    bus_read(A_INIT, v); check("R3 init 3 ignored", v, 16'd5);
        bus_write(A_INIT, RSZ, 16'd0);    bus_read(A_INIT, v); check("R3 init 0 ignored", v, 16'd5);
        bus_write(A_INIT, RSZ, 16'hFC07); bus_read(A_INIT, v); check("R3 upper bits ignored", v, 16'd7);
        bus_write(A_INIT, RSZ, 16'd4);    bus_read(A_INIT, v); check("R3 floor value 4", v, 16'd4);
        bus_write(A_INIT, RSZ, 16'd5);

        // R2 control readback, start counting
        bus_write(5'h08, 1'b1, 16'hF7FF); bus_read(5'h08, v); check("R2 ctl1 reads halt only", v, 16'h0000);

        // R4 reload
        bus_write(5'h00, RSZ, 16'h0001);
        bus_read(5'h00, v); check("R4 reload loads init", v, 16'd5);
        idle(9);
        bus_read(5'h00, v); check("R5 count readback", v, 16'(m_cnt));
        held = 16'(m_cnt);
        bus_write(5'h00, RSZ, 16'h0002);
        bus_read(5'h00, v); check("R4 value 2 no reload", v, 16'(m_cnt));
        bus_write(5'h00, ~RSZ, 16'h0001);
        bus_read(5'h00, v); check("R4 wrong size no reload", v, 16'(m_cnt));
        check("R4 count moved on", {31'b0, (v != 16'd5)}, 32'd1);

        // R6 first expiry
        bus_write(5'h00, RSZ, 16'h0001);
        idle(30);
        bus_read(5'h04, v); check("R6 timeout flag", v, 16'h0008);
        bus_read(5'h00, v); check("R6 count after expiry", v, 16'(m_cnt));

        // R7 write-one-to-clear
        bus_write(5'h04, 1'b1, 16'h0000); bus_read(5'h04, v); check("R7 zero keeps flag", v, 16'h0008);
        bus_write(5'h04, 1'b1, 16'h0008); bus_read(5'h04, v); check("R7 one clears flag", v, 16'h0000);

        // R9 second expiry with inhibit set: flag but no pulse
        idle(26);
        bus_read(5'h06, v); check("R8 second flag", v, 16'h0002);
        check("R9 inhibited no pulse", n_pulse, 0);
        bus_write(5'h06, 1'b1, 16'h0002); bus_read(5'h06, v); check("R7 clear sts2", v, 16'h0000);

        // R9 clear inhibit, R8 pulse on second expiry
        bus_write(5'h0A, 1'b1, 16'h0000); bus_read(5'h0A, v); check("R9 inhibit cleared", v, 16'h0000);
        bus_write(5'h00, RSZ, 16'h0001);
        idle(56);
        check("R8 one reset pulse", n_pulse, 1);
        bus_read(5'h06, v); check("R8 second flag set", v, 16'h0002);

        // R10 reload between expiries cancels second-expiry path
        bus_write(5'h06, 1'b1, 16'h0002);
        for (int i = 0; i < 3; i++) begin
            bus_write(5'h00, RSZ, 16'h0001);
            idle(26);
        end
        check("R10 no pulse with reloads", n_pulse, 1);
        bus_read(5'h06, v); check("R10 no second flag", v, 16'h0000);

        // R2 halt freezes mid-count
        bus_write(5'h08, 1'b1, 16'h0800);
        bus_read(5'h00, held);
        idle(40);
        bus_read(5'h00, v); check("R2 halt freezes count", v, held);
        check("R5 frozen count vs model", v, 16'(m_cnt));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule